// File: doc/BRIEF.md
# Periodic Oscillator Trim Unit

This block derives a one-second tick from a slow oscillator and corrects the frequency error of that oscillator. It does so by changing the length of a single second once per correction window. Each oscillator cycle arrives as a one-cycle enable strobe on the system clock. A prescaler counts these strobes. When a second ends it raises a one-cycle tick and starts counting again.

Software programs a trim byte and a control pair. The top two bits of the trim byte select the direction and the low six bits give a cycle count. The control pair is a window-length select and a trim enable. The last second of every window is then shortened or lengthened by the programmed count, and all other seconds keep the nominal length.

The window-length select has an interlock. While the stored direction code is nonzero, a control write cannot change the window length. The trim must first be returned to the idle code.

Top module: `clk_trim_unit`

## Requirements
- R1: After a synchronous active-low reset, the trim byte reads 0x00, the window select reads 0 (long window), the enable reads 0, and the second tick is low.
- R2: Seconds that are not trimmed last exactly NOM_DIV oscillator strobes. The tick is a one-cycle pulse in the clock cycle after the strobe that ends the second.
- R3: Direction code 1 (trim byte bits 7:6 = 01) with the enable set shortens the last second of each window by the count in bits 5:0. A count of 0 leaves the second at nominal length.
- R4: Direction code 2 (bits 7:6 = 10) with the enable set lengthens the last second of each window by the count in bits 5:0.
- R5: Direction code 0 and the reserved code 3 apply no trim, so every second has nominal length.
- R6: With the enable bit clear, no second is trimmed, whatever the trim byte holds.
- R7: Seconds are numbered from 0 after reset. With window select 1 the window is SHORT_SECS seconds and seconds 9, 19, and so on are trimmed. With window select 0 the window is LONG_SECS seconds and seconds 59, 119, and so on are trimmed. These numbers use the default window lengths.
- R8: A control write leaves the window select unchanged while the stored direction code is nonzero. The enable bit of the same write is still stored. When the stored code is 0, the window select takes the written value.
- R9: The prescaler advances only on cycles with an oscillator strobe. A cycle without a strobe is never followed by a tick, and strobe-free cycles stretch the second in clock cycles.
- R10: The trim byte holds its value between writes and reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One strobe per oscillator cycle |
| adj_we | input | 1 | Write strobe for the trim byte |
| adj_wdata | input | ADJ_W+2 | Trim byte: direction in the top two bits, cycle count below them |
| ctl_we | input | 1 | Write strobe for the control pair |
| ctl_interval_short | input | 1 | Window select: 1 selects the short window, 0 the long window |
| ctl_auto_en | input | 1 | Trim enable |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |
| adj_rdata | output | ADJ_W+2 | Stored trim byte |
| interval_short_q | output | 1 | Stored window select |
| auto_en_q | output | 1 | Stored trim enable |

## Verification
A wrong window index or a wrong stored period appears at the port only as tick spacing. An error in the window index therefore stays hidden until the next trimmed second, which can be up to one full window away. The bench measures every second over two full windows so that such an error is seen. A wrong prescaler count shifts the very next tick, and a broken interlock shows on the window-select readback in the cycle after the control write.

// File: rtl/clk_trim_pkg.sv
// Shared types for the oscillator trim unit.
// Assumes: direction codes sit in the top two bits of the trim byte.
package clk_trim_pkg;
    typedef enum logic [1:0] {
        TRIM_OFF  = 2'd0,
        TRIM_FAST = 2'd1,
        TRIM_SLOW = 2'd2,
        TRIM_RSVD = 2'd3
    } trim_mode_e;
endpackage

// File: rtl/trim_cfg_regs.sv
// Configuration storage for the trim unit: the trim byte, the window select and the enable.
// Assumes: the window-select interlock looks at the stored direction code,
// not at a trim-byte write in the same cycle.
module trim_cfg_regs #(
    parameter int ADJ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adj_we,
    input  logic [ADJ_W+1:0] adj_wdata,
    input  logic             ctl_we,
    input  logic             ctl_short,
    input  logic             ctl_auto,
    output logic [ADJ_W+1:0] adj_q,
    output logic             short_q,
    output logic             auto_q
);
    logic mode_idle;

    // Window select may only change while no trim direction is stored.
    assign mode_idle = (adj_q[ADJ_W+1:ADJ_W] == 2'b00);

    // Register writes with the window-select interlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q   <= '0;
            short_q <= 1'b0;
            auto_q  <= 1'b0;
        end else begin
            if (adj_we) adj_q <= adj_wdata;
            if (ctl_we) begin
                auto_q <= ctl_auto;
                if (mode_idle) short_q <= ctl_short;
            end
        end
    end
endmodule

// File: rtl/trim_period_sel.sv
// Keeps track of the second index inside the window and selects the terminal count for the next second.
// Assumes: SHORT_SECS <= LONG_SECS and both are at least 2; NOM_DIV > 2**ADJ_W.
module trim_period_sel
    import clk_trim_pkg::*;
#(
    parameter int NOM_DIV    = 32768,
    parameter int SHORT_SECS = 10,
    parameter int LONG_SECS  = 60,
    parameter int ADJ_W      = 6,
    parameter int CNT_W      = 16,
    parameter int WIN_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_end,
    input  logic [ADJ_W+1:0] adj_q,
    input  logic             short_q,
    input  logic             auto_q,
    output logic [CNT_W-1:0] term_q
);
    localparam logic [CNT_W-1:0] NOM_TERM   = CNT_W'(NOM_DIV - 1);
    localparam logic [WIN_W-1:0] SHORT_LAST = WIN_W'(SHORT_SECS - 1);
    localparam logic [WIN_W-1:0] LONG_LAST  = WIN_W'(LONG_SECS - 1);

    logic [WIN_W-1:0] win_idx, idx_next, last_idx;
    logic [CNT_W-1:0] cnt_ext, term_next;
    trim_mode_e       mode;
    logic             trim_on;

    // Decode the stored trim byte.
    assign mode     = trim_mode_e'(adj_q[ADJ_W+1:ADJ_W]);
    assign cnt_ext  = {{(CNT_W-ADJ_W){1'b0}}, adj_q[ADJ_W-1:0]};
    assign trim_on  = auto_q && (mode == TRIM_FAST || mode == TRIM_SLOW);
    assign last_idx = short_q ? SHORT_LAST : LONG_LAST;
    assign idx_next = (win_idx >= last_idx) ? '0 : win_idx + 1'b1;

    // Terminal count of the coming second: only the last second of the window is trimmed.
    always_comb begin
        term_next = NOM_TERM;
        if (trim_on && idx_next == last_idx) begin
            if (mode == TRIM_FAST) term_next = NOM_TERM - cnt_ext;
            else                   term_next = NOM_TERM + cnt_ext;
        end
    end

    // Move to the next second and load its terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_idx <= '0;
            term_q  <= NOM_TERM;
        end else if (sec_end) begin
            win_idx <= idx_next;
            term_q  <= term_next;
        end
    end
endmodule

// File: rtl/sec_prescaler.sv
// Counts oscillator strobes up to a terminal count that can be reloaded, and emits the second tick.
// Assumes: the terminal count changes only in the cycle in which the counter restarts.
module sec_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [CNT_W-1:0] term,
    output logic             sec_end,
    output logic             sec_tick
);
    logic [CNT_W-1:0] cnt;

    // A second ends on the strobe that reaches the terminal count.
    assign sec_end = osc_tick && (cnt >= term);

    // Strobe counter and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= sec_end;
            if (sec_end)       cnt <= '0;
            else if (osc_tick) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clk_trim_unit.sv
// Top of the oscillator trim unit: configuration registers, period selection and prescaler.
// Assumes: osc_tick is already synchronous to clk; NOM_DIV > 2**ADJ_W.
module clk_trim_unit #(
    parameter int NOM_DIV    = 32768,
    parameter int SHORT_SECS = 10,
    parameter int LONG_SECS  = 60,
    parameter int ADJ_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             adj_we,
    input  logic [ADJ_W+1:0] adj_wdata,
    input  logic             ctl_we,
    input  logic             ctl_interval_short,
    input  logic             ctl_auto_en,
    output logic             sec_tick,
    output logic [ADJ_W+1:0] adj_rdata,
    output logic             interval_short_q,
    output logic             auto_en_q
);
    localparam int ADJ_MAX = (1 << ADJ_W) - 1;
    localparam int CNT_W   = $clog2(NOM_DIV + ADJ_MAX + 1);
    localparam int WIN_W   = $clog2(LONG_SECS + 1);

    logic [CNT_W-1:0] term;
    logic             sec_end;

    trim_cfg_regs #(.ADJ_W(ADJ_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .adj_we(adj_we), .adj_wdata(adj_wdata),
        .ctl_we(ctl_we), .ctl_short(ctl_interval_short), .ctl_auto(ctl_auto_en),
        .adj_q(adj_rdata), .short_q(interval_short_q), .auto_q(auto_en_q)
    );

    trim_period_sel #(
        .NOM_DIV(NOM_DIV), .SHORT_SECS(SHORT_SECS), .LONG_SECS(LONG_SECS),
        .ADJ_W(ADJ_W), .CNT_W(CNT_W), .WIN_W(WIN_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .sec_end(sec_end),
        .adj_q(adj_rdata), .short_q(interval_short_q), .auto_q(auto_en_q),
        .term_q(term)
    );

    sec_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .term(term),
        .sec_end(sec_end), .sec_tick(sec_tick)
    );
endmodule

// File: rtl/clk_trim_chk.sv
// Property checker for the trim unit. It is attached to every instance of the top through bind.
// Assumes: a tick marks the end of a second whose strobe count has already been counted.
module clk_trim_chk #(
    parameter int NOM_DIV = 32768,
    parameter int ADJ_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_tick,
    input logic             adj_we,
    input logic             ctl_we,
    input logic             ctl_auto_en,
    input logic             sec_tick,
    input logic [ADJ_W+1:0] adj_rdata,
    input logic             interval_short_q,
    input logic             auto_en_q
);
    localparam int ADJ_MAX = (1 << ADJ_W) - 1;
    localparam int GAP_W   = $clog2(NOM_DIV + ADJ_MAX + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_LO = GAP_W'(NOM_DIV - ADJ_MAX);
    localparam logic [GAP_W-1:0] GAP_HI = GAP_W'(NOM_DIV + ADJ_MAX);

    logic [GAP_W-1:0] gap;
    logic             seen;

    // Count the strobes between ticks; the count starts after the first tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (sec_tick) begin
            gap  <= osc_tick ? GAP_W'(1) : '0;
            seen <= 1'b1;
        end else if (osc_tick) begin
            gap  <= gap + 1'b1;
        end
    end

    AST_TICK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> !sec_tick); // R9
    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && seen) |-> (gap >= GAP_LO && gap <= GAP_HI)); // R3
    AST_INTERVAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && adj_rdata[ADJ_W+1:ADJ_W] != 2'b00) |=> $stable(interval_short_q)); // R8
    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (auto_en_q == $past(ctl_auto_en))); // R8
    AST_ADJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adj_we |=> $stable(adj_rdata)); // R10
endmodule

bind clk_trim_unit clk_trim_chk #(.NOM_DIV(NOM_DIV), .ADJ_W(ADJ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .adj_we(adj_we),
    .ctl_we(ctl_we), .ctl_auto_en(ctl_auto_en), .sec_tick(sec_tick),
    .adj_rdata(adj_rdata), .interval_short_q(interval_short_q),
    .auto_en_q(auto_en_q)
);

// File: tb/clk_trim_unit_tb.sv
// Bench for the trim unit. It sweeps direction, count, enable and window length on a small divider
// and checks the length of every second against values computed in the bench.
module clk_trim_unit_tb;
    localparam int NOM   = 128;
    localparam int SHORT = 10;
    localparam int LONG  = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       adj_we = 1'b0;
    logic [7:0] adj_wdata = '0;
    logic       ctl_we = 1'b0;
    logic       ctl_interval_short = 1'b0;
    logic       ctl_auto_en = 1'b0;
    logic       sec_tick;
    logic [7:0] adj_rdata;
    logic       interval_short_q;
    logic       auto_en_q;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_t = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clk_trim_unit #(.NOM_DIV(NOM), .SHORT_SECS(SHORT), .LONG_SECS(LONG), .ADJ_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .adj_we(adj_we), .adj_wdata(adj_wdata),
        .ctl_we(ctl_we), .ctl_interval_short(ctl_interval_short), .ctl_auto_en(ctl_auto_en),
        .sec_tick(sec_tick), .adj_rdata(adj_rdata),
        .interval_short_q(interval_short_q), .auto_en_q(auto_en_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; osc_tick = 1'b1; adj_we = 1'b0; ctl_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_adj(input logic [7:0] d);
        adj_wdata = d; adj_we = 1'b1;
        @(negedge clk);
        adj_we = 1'b0;
    endtask

    task automatic write_ctl(input logic s, input logic en);
        ctl_interval_short = s; ctl_auto_en = en; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!sec_tick);
        last_t = cyc;
    endtask

    // One configuration: measure every second over two windows.
    task automatic run_case(input int mode, input int n, input bit s, input bit en, input string tag);
        int lim, t0, exp;
        do_reset();
        write_ctl(s, en);
        write_adj({mode[1:0], n[5:0]});
        lim = s ? SHORT : LONG;
        wait_pulse();
        t0 = last_t;
        for (int k = 1; k < 2 * lim; k++) begin
            wait_pulse();
            exp = NOM;
            if ((k % lim) == lim - 1 && en) begin
                if (mode == 1) exp = NOM - n;
                else if (mode == 2) exp = NOM + n;
            end
            chk(last_t - t0 == exp, tag, last_t - t0, exp);
            t0 = last_t;
        end
    endtask

    initial begin
        int t0;
        bit quiet;
        // R1 reset state
        do_reset();
        chk(adj_rdata == 8'h00, "R1", adj_rdata, 0);
        chk(interval_short_q == 1'b0, "R1", interval_short_q, 0);
        chk(auto_en_q == 1'b0, "R1", auto_en_q, 0);
        chk(sec_tick == 1'b0, "R1", sec_tick, 0);

        // R2 nominal length and single-cycle pulse
        run_case(0, 0, 1'b1, 1'b1, "R2");
        @(negedge clk);
        chk(sec_tick == 1'b0, "R2", sec_tick, 0);

        // R3 R4 R5: sweep direction and count on the short window
        for (int m = 0; m < 4; m++) begin
            for (int j = 0; j < 4; j++) begin
                int n;
                n = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 17 : 63;
                run_case(m, n, 1'b1, 1'b1, (m == 1) ? "R3" : (m == 2) ? "R4" : "R5");
            end
        end

        // R6: enable clear suppresses trimming
        run_case(1, 63, 1'b1, 1'b0, "R6");
        run_case(2, 40, 1'b1, 1'b0, "R6");

        // R7: long window
        run_case(1, 63, 1'b0, 1'b1, "R7");
        run_case(2, 40, 1'b0, 1'b1, "R7");

        // R8: window-select interlock
        do_reset();
        write_adj(8'h45);
        write_ctl(1'b1, 1'b1);
        chk(interval_short_q == 1'b0, "R8", interval_short_q, 0);
        chk(auto_en_q == 1'b1, "R8", auto_en_q, 1);
        write_adj(8'h00);
        write_ctl(1'b1, 1'b1);
        chk(interval_short_q == 1'b1, "R8", interval_short_q, 1);
        write_adj(8'hC3);
        write_ctl(1'b0, 1'b0);
        chk(interval_short_q == 1'b1, "R8", interval_short_q, 1);
        chk(auto_en_q == 1'b0, "R8", auto_en_q, 0);

        // R10: trim byte holds and reads back
        write_adj(8'hA7);
        chk(adj_rdata == 8'hA7, "R10", adj_rdata, 'hA7);
        repeat (5) @(negedge clk);
        write_ctl(1'b0, 1'b1);
        chk(adj_rdata == 8'hA7, "R10", adj_rdata, 'hA7);

        // R9: strobe-free cycles stall the prescaler
        do_reset();
        wait_pulse();
        t0 = last_t;
        osc_tick = 1'b0;
        quiet = 1'b1;
        repeat (37) begin
            @(negedge clk);
            if (sec_tick) quiet = 1'b0;
        end
        osc_tick = 1'b1;
        chk(quiet, "R9", quiet, 1);
        wait_pulse();
        chk(last_t - t0 == NOM + 37, "R9", last_t - t0, NOM + 37);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule